// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block collects the interrupt conditions of a serial port and turns them into one interrupt request line plus a 4-bit identification code that software reads to find out why it was interrupted. Five conditions are tracked: a receive line error, received data ready, a receive character timeout, the transmit holding register having gone empty, and a change on the modem control lines. Each condition is latched as pending when its event input pulses. It stays pending until software performs the register access that services it.

Software reads the code, services the reported cause, and reads the code again. A lower-priority cause becomes visible only once every higher one has been cleared. A 4-bit enable word hides any cause from both the code and the request line. A hidden cause stays latched, so it appears as soon as its enable bit is set.

Top module: `uart_irq_ident`

## Requirements
- R1: Reset clears all pending conditions; afterwards `iid_o` reads 4'b0001 and `irq_o` is low.
- R2: A pending, enabled line-error condition is reported as 4'b0110 and is cleared by a pulse on `lsr_rd_i`.
- R3: A pending, enabled data-ready condition is reported as 4'b0100 and is cleared by a pulse on `rbr_rd_i`.
- R4: A pending, enabled character-timeout condition is reported as 4'b1100 and is also cleared by `rbr_rd_i`; one `rbr_rd_i` pulse clears data-ready and timeout together.
- R5: A pending, enabled transmit-empty condition is reported as 4'b0010 and is cleared by a pulse on `thr_wr_i`.
- R6: A pulse on `iid_rd_i` clears transmit-empty only when `iid_o` shows 4'b0010 in that same cycle; otherwise transmit-empty stays pending.
- R7: A pending, enabled modem-change condition is reported as 4'b0000 and is cleared by a pulse on `msr_rd_i`.
- R8: With several conditions pending, `iid_o` reports the highest one in the order line error, data ready, timeout, transmit empty, modem change. After the reported one is cleared, the next one appears.
- R9: Enable bits: bit 0 gates data-ready and timeout, bit 1 gates transmit-empty, bit 2 gates line error, bit 3 gates modem change. A disabled condition still latches but affects neither output. With no enabled condition pending, `iid_o` is 4'b0001.
- R10: `irq_o` is a register. It is high in the cycle after a cycle in which an enabled condition is pending, and low in the cycle after a cycle in which none is.
- R11: An event pulse arriving in the same cycle as that condition's clear access leaves the condition pending.
- R12: A condition becomes pending, and `iid_o` reflects it, in the cycle right after its event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ls_evt_i | input | 1 | Receive line error event pulse |
| rd_evt_i | input | 1 | Received data ready event pulse |
| to_evt_i | input | 1 | Receive character timeout event pulse |
| te_evt_i | input | 1 | Transmit holding register empty event pulse |
| ms_evt_i | input | 1 | Modem line change event pulse |
| iid_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit buffer write strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| irq_en_i | input | 4 | Per-source enable mask |
| iid_o | output | 4 | Identification code of the highest pending cause |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An event or a clearing access sampled at one rising edge changes `iid_o` right after that edge, which is one cycle of latency. `irq_o` follows one edge later, which is two cycles after the event. The bench drives inputs on falling edges, advances its reference model at each rising edge from the values held there, and compares both outputs at the next falling edge. Each comparison therefore lands in the first cycle where the new value is due. Because `irq_o` is compared every cycle, an early or late request is caught in the first cycle it goes wrong.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 5;
    localparam int CODE_W  = 4;
    localparam int EN_W    = 4;

    // Source indices, in descending priority.
    localparam int S_LS = 0;
    localparam int S_RD = 1;
    localparam int S_TO = 2;
    localparam int S_TE = 3;
    localparam int S_MS = 4;

    // Enable bit positions.
    localparam int E_RX = 0;
    localparam int E_TE = 1;
    localparam int E_LS = 2;
    localparam int E_MS = 3;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [NUM_SRC-1:0] src_vec_t;

    localparam code_t CODE_NONE = 4'b0001;
    localparam code_t CODE_LS   = 4'b0110;
    localparam code_t CODE_RD   = 4'b0100;
    localparam code_t CODE_TO   = 4'b1100;
    localparam code_t CODE_TE   = 4'b0010;
    localparam code_t CODE_MS   = 4'b0000;

    typedef struct packed {
        logic iid_rd;
        logic lsr_rd;
        logic rbr_rd;
        logic thr_wr;
        logic msr_rd;
    } access_t;

    function automatic code_t src_code(input int idx);
        code_t c;
        case (idx)
            S_LS:    c = CODE_LS;
            S_RD:    c = CODE_RD;
            S_TO:    c = CODE_TO;
            S_TE:    c = CODE_TE;
            S_MS:    c = CODE_MS;
            default: c = CODE_NONE;
        endcase
        return c;
    endfunction

    // Widen the enable word to one gate per source.
    function automatic src_vec_t expand_en(input logic [EN_W-1:0] en);
        src_vec_t g;
        g       = '0;
        g[S_LS] = en[E_LS];
        g[S_RD] = en[E_RX];
        g[S_TO] = en[E_RX];
        g[S_TE] = en[E_TE];
        g[S_MS] = en[E_MS];
        return g;
    endfunction

endpackage

// File: rtl/uart_irq_src_flags.sv
module uart_irq_src_flags
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                pend_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                pend_o[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  src_vec_t        pend_i,
    input  logic [EN_W-1:0] en_i,
    output src_vec_t        act_o,
    output code_t           code_o,
    output logic            any_o
);

    always_comb begin
        act_o  = pend_i & expand_en(en_i);
        code_o = CODE_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (act_o[i]) begin
                code_o = src_code(i);
            end
        end
        any_o = |act_o;
    end

endmodule

// File: rtl/uart_irq_clear_map.sv
module uart_irq_clear_map
    import uart_irq_pkg::*;
(
    input  access_t  acc_i,
    input  code_t    code_i,
    output src_vec_t clr_o
);

    always_comb begin
        clr_o       = '0;
        clr_o[S_LS] = acc_i.lsr_rd;
        clr_o[S_RD] = acc_i.rbr_rd;
        clr_o[S_TO] = acc_i.rbr_rd;
        clr_o[S_TE] = acc_i.thr_wr | (acc_i.iid_rd && (code_i == CODE_TE));
        clr_o[S_MS] = acc_i.msr_rd;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ls_evt_i,
    input  logic            rd_evt_i,
    input  logic            to_evt_i,
    input  logic            te_evt_i,
    input  logic            ms_evt_i,
    input  logic            iid_rd_i,
    input  logic            lsr_rd_i,
    input  logic            rbr_rd_i,
    input  logic            thr_wr_i,
    input  logic            msr_rd_i,
    input  logic [EN_W-1:0] irq_en_i,
    output logic [CODE_W-1:0] iid_o,
    output logic            irq_o
);

    src_vec_t set_vec;
    src_vec_t clr_vec;
    src_vec_t pend;
    src_vec_t act;
    code_t    code;
    logic     any_act;
    access_t  acc;
    logic     irq_q;

    always_comb begin
        set_vec       = '0;
        set_vec[S_LS] = ls_evt_i;
        set_vec[S_RD] = rd_evt_i;
        set_vec[S_TO] = to_evt_i;
        set_vec[S_TE] = te_evt_i;
        set_vec[S_MS] = ms_evt_i;
        acc.iid_rd    = iid_rd_i;
        acc.lsr_rd    = lsr_rd_i;
        acc.rbr_rd    = rbr_rd_i;
        acc.thr_wr    = thr_wr_i;
        acc.msr_rd    = msr_rd_i;
    end

    uart_irq_src_flags #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    uart_irq_prio u_prio (
        .pend_i (pend),
        .en_i   (irq_en_i),
        .act_o  (act),
        .code_o (code),
        .any_o  (any_act)
    );

    uart_irq_clear_map u_clr (
        .acc_i  (acc),
        .code_i (code),
        .clr_o  (clr_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= any_act;
        end
    end

    assign iid_o = code;
    assign irq_o = irq_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_irq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ls_evt_i,
    input logic            rd_evt_i,
    input logic            to_evt_i,
    input logic            te_evt_i,
    input logic            ms_evt_i,
    input logic            lsr_rd_i,
    input logic            rbr_rd_i,
    input logic            thr_wr_i,
    input logic            msr_rd_i,
    input logic [EN_W-1:0] irq_en_i,
    input logic [CODE_W-1:0] iid_o,
    input logic            irq_o
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!irq_o && iid_o == 4'b0001));

    a_r2_ls_cleared: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd_i && !ls_evt_i) |=> (iid_o != 4'b0110));

    a_r4_rx_cleared: assert property (@(posedge clk) disable iff (rst)
        (rbr_rd_i && !rd_evt_i && !to_evt_i) |=> (iid_o != 4'b0100 && iid_o != 4'b1100));

    a_r5_te_cleared: assert property (@(posedge clk) disable iff (rst)
        (thr_wr_i && !te_evt_i) |=> (iid_o != 4'b0010));

    a_r7_ms_cleared: assert property (@(posedge clk) disable iff (rst)
        (msr_rd_i && !ms_evt_i) |=> (iid_o != 4'b0000));

    a_r11_ls_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ls_evt_i && irq_en_i[E_LS] && $stable(irq_en_i)) |=> (iid_o == 4'b0110));

    a_r10_irq_registered: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_o == !$past(iid_o[0])));

    always_comb begin
        if (!rst) begin
            a_r9_code_legal: assert (iid_o inside {4'b0001, 4'b0110, 4'b0100,
                                                   4'b1100, 4'b0010, 4'b0000});
        end
    end

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ls_evt_i (ls_evt_i),
    .rd_evt_i (rd_evt_i),
    .to_evt_i (to_evt_i),
    .te_evt_i (te_evt_i),
    .ms_evt_i (ms_evt_i),
    .lsr_rd_i (lsr_rd_i),
    .rbr_rd_i (rbr_rd_i),
    .thr_wr_i (thr_wr_i),
    .msr_rd_i (msr_rd_i),
    .irq_en_i (irq_en_i),
    .iid_o    (iid_o),
    .irq_o    (irq_o)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ls_evt = 0, rd_evt = 0, to_evt = 0, te_evt = 0, ms_evt = 0;
    logic       iid_rd = 0, lsr_rd = 0, rbr_rd = 0, thr_wr = 0, msr_rd = 0;
    logic [3:0] en = 4'hF;
    logic [3:0] iid;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_ls = 0, m_rd = 0, m_to = 0, m_te = 0, m_ms = 0;
    bit m_irq = 0;

    always #10 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk      (clk),
        .rst      (rst),
        .ls_evt_i (ls_evt),
        .rd_evt_i (rd_evt),
        .to_evt_i (to_evt),
        .te_evt_i (te_evt),
        .ms_evt_i (ms_evt),
        .iid_rd_i (iid_rd),
        .lsr_rd_i (lsr_rd),
        .rbr_rd_i (rbr_rd),
        .thr_wr_i (thr_wr),
        .msr_rd_i (msr_rd),
        .irq_en_i (en),
        .iid_o    (iid),
        .irq_o    (irq)
    );

    function automatic logic [3:0] ref_code();
        if (en[2] && m_ls) return 4'b0110;
        if (en[0] && m_rd) return 4'b0100;
        if (en[0] && m_to) return 4'b1100;
        if (en[1] && m_te) return 4'b0010;
        if (en[3] && m_ms) return 4'b0000;
        return 4'b0001;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ls = 0; m_rd = 0; m_to = 0; m_te = 0; m_ms = 0; m_irq = 0;
        end else begin
            logic [3:0] c;
            c = ref_code();
            m_irq = (c != 4'b0001);
            if (lsr_rd) m_ls = 0;
            if (rbr_rd) begin m_rd = 0; m_to = 0; end
            if (thr_wr || (iid_rd && c == 4'b0010)) m_te = 0;
            if (msr_rd) m_ms = 0;
            if (ls_evt) m_ls = 1;
            if (rd_evt) m_rd = 1;
            if (to_evt) m_to = 1;
            if (te_evt) m_te = 1;
            if (ms_evt) m_ms = 1;
        end
    end

    task automatic check(input string tag, input logic [3:0] exp_iid, input logic exp_irq);
        checks++;
        if (iid !== exp_iid) begin
            errors++;
            $display("FAIL %s iid actual %b expected %b at %0t", tag, iid, exp_iid, $time);
        end
        checks++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b at %0t", tag, irq, exp_irq, $time);
        end
    endtask

    // Advance one clock, compare against the model, then drop the pulses.
    task automatic cyc(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, ref_code(), m_irq);
        ls_evt = 0; rd_evt = 0; to_evt = 0; te_evt = 0; ms_evt = 0;
        iid_rd = 0; lsr_rd = 0; rbr_rd = 0; thr_wr = 0; msr_rd = 0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1", 4'b0001, 1'b0);
        rst = 0;
        cyc("R1");
        check("R1", 4'b0001, 1'b0);

        // R2 / R12 / R10: line error
        ls_evt = 1; cyc("R12");
        check("R2", 4'b0110, 1'b0);
        cyc("R10");
        check("R10", 4'b0110, 1'b1);
        lsr_rd = 1; cyc("R2");
        check("R2", 4'b0001, 1'b1);
        cyc("R10");
        check("R10", 4'b0001, 1'b0);

        // R3 / R4: data ready and timeout, one receive read clears both
        rd_evt = 1; to_evt = 1; cyc("R3");
        check("R3", 4'b0100, 1'b0);
        cyc("R4");
        rbr_rd = 1; cyc("R4");
        check("R4", 4'b0001, 1'b1);
        to_evt = 1; cyc("R4");
        check("R4", 4'b1100, 1'b0);
        rbr_rd = 1; cyc("R4");
        cyc("R4");

        // R5: transmit empty cleared by write
        te_evt = 1; cyc("R5");
        check("R5", 4'b0010, 1'b0);
        thr_wr = 1; cyc("R5");
        check("R5", 4'b0001, 1'b1);

        // R6: identification read clears transmit-empty only when reported
        te_evt = 1; ls_evt = 1; cyc("R6");
        iid_rd = 1; cyc("R6");
        check("R6", 4'b0110, 1'b1);
        lsr_rd = 1; cyc("R6");
        check("R6", 4'b0010, 1'b1);
        iid_rd = 1; cyc("R6");
        check("R6", 4'b0001, 1'b1);

        // R7: modem change
        ms_evt = 1; cyc("R7");
        check("R7", 4'b0000, 1'b0);
        msr_rd = 1; cyc("R7");
        check("R7", 4'b0001, 1'b1);
        cyc("R7");

        // R8: all five pending, serviced in priority order
        ls_evt = 1; rd_evt = 1; to_evt = 1; te_evt = 1; ms_evt = 1; cyc("R8");
        check("R8", 4'b0110, 1'b0);
        lsr_rd = 1; cyc("R8");
        check("R8", 4'b0100, 1'b1);
        rbr_rd = 1; cyc("R8");
        check("R8", 4'b0010, 1'b1);
        thr_wr = 1; cyc("R8");
        check("R8", 4'b0000, 1'b1);
        msr_rd = 1; cyc("R8");
        check("R8", 4'b0001, 1'b1);
        cyc("R8");

        // R9: masked sources latch but stay hidden
        en = 4'h0;
        ls_evt = 1; rd_evt = 1; te_evt = 1; ms_evt = 1; cyc("R9");
        cyc("R9");
        check("R9", 4'b0001, 1'b0);
        en = 4'b1000; cyc("R9");
        check("R9", 4'b0000, 1'b1);
        en = 4'b1010; cyc("R9");
        check("R9", 4'b0010, 1'b1);
        en = 4'b1011; cyc("R9");
        check("R9", 4'b0100, 1'b1);
        en = 4'b1111; cyc("R9");
        check("R9", 4'b0110, 1'b1);
        lsr_rd = 1; rbr_rd = 1; thr_wr = 1; msr_rd = 1; cyc("R9");
        cyc("R9");

        // R11: event and clear in the same cycle
        ls_evt = 1; cyc("R11");
        ls_evt = 1; lsr_rd = 1; cyc("R11");
        check("R11", 4'b0110, 1'b1);
        te_evt = 1; thr_wr = 1; lsr_rd = 1; cyc("R11");
        check("R11", 4'b0010, 1'b1);
        te_evt = 1; iid_rd = 1; cyc("R11");
        check("R11", 4'b0010, 1'b1);
        thr_wr = 1; cyc("R11");

        // R8 / R10: pseudo-random mix compared against the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ls_evt = (lfsr[2:0] == 3'd0);
            rd_evt = (lfsr[4:2] == 3'd1);
            to_evt = (lfsr[6:4] == 3'd2);
            te_evt = (lfsr[8:6] == 3'd3);
            ms_evt = (lfsr[10:8] == 3'd4);
            iid_rd = lfsr[11];
            lsr_rd = (lfsr[13:12] == 2'd0);
            rbr_rd = (lfsr[14:13] == 2'd1);
            thr_wr = (lfsr[15:14] == 2'd2);
            msr_rd = (lfsr[1:0] == 2'd3) && lfsr[9];
            if (k % 97 == 0) en = lfsr[7:4];
            cyc("R8");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule